// File: doc/BRIEF.md
# Serial EEPROM Transaction Controller

This block is the protocol layer of a two-wire serial EEPROM slave. A byte-level front end, which handles the bus lines, reports START and STOP events, received bytes and the master's acknowledge bits. This block decides whether each received byte is acknowledged. It keeps the word-address counter and returns read data one byte at a time. The storage array sits inside the block as a register array of `2**ADDR_W` bytes.

Writes land in a page buffer first. Each byte received sets one bit in a byte-valid mask. On STOP, the bytes that were received are copied into the array during a self-timed busy period that lasts `WR_CYCLES` clock cycles. While that period runs, the block ignores its inputs and refuses every device select, so a host can poll until the write is done. Reads cover three cases: reading at the current address, a random read set up by a dummy write, and sequential reads that wrap across the whole array. A write-protect input blocks every commit.

Top module: `eeprom_xact_ctrl`

## Requirements
- R1: A received byte after START is a device select. It matches when bits 7:4 equal 4'b1010 and bits 3:1 equal `sel_pins`. Bit 0 set to 1 selects a read and 0 selects a write. Every `rx_valid` is answered by `ack_valid` one cycle later. `ack` is 1 only for an accepted byte, so a select that does not match gets `ack`=0.
- R2: After a write select, two address bytes follow, high byte first. Both are acknowledged. Address bits above `ADDR_W` are ignored.
- R3: Each data byte in a write is acknowledged and buffered. After each byte, only the low 5 address bits step. Past the end of the page, the address wraps to the start of the same page and overwrites earlier bytes.
- R4: A STOP after a write with at least one buffered byte commits only the bytes received. `busy` rises one cycle after STOP and stays high for exactly `WR_CYCLES` cycles.
- R5: While `busy` is high, device selects get `ack`=0, no read data is sent and received bytes change nothing.
- R6: A read select returns the byte at the address counter. The counter then points one past the last byte read or written, and it keeps that value across transactions.
- R7: A write select followed by two address bytes and a repeated START loads the address only: no write takes place and `busy` stays low.
- R8: After a read byte, a master acknowledge of 1 sends the next byte one cycle later. The address rolls from the top of the array to 0. A master acknowledge of 0 ends the read with no further byte.
- R9: With `wp` high, data bytes are still acknowledged, but nothing is written and `busy` does not rise at STOP.
- R10: After reset, `busy`, `ack_valid` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_pins | input | 3 | Strapped device-select bits |
| wp | input | 1 | Write protect, high blocks commits |
| ev_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| ev_stop | input | 1 | STOP seen (one-cycle pulse) |
| rx_valid | input | 1 | A byte from the master is ready |
| rx_byte | input | 8 | Received byte |
| ack_valid | output | 1 | Response to the previous `rx_valid` |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| tx_valid | output | 1 | Read byte ready for the front end |
| tx_byte | output | 8 | Read byte |
| mack_valid | input | 1 | Master acknowledge bit after a read byte is ready |
| mack | input | 1 | Master acknowledge (1 = continue) |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Every response is registered once. `ack_valid`/`ack` follow `rx_valid` by one cycle. `tx_valid`/`tx_byte` follow either a read select or a master acknowledge by one cycle. `busy` rises one cycle after the STOP pulse. The bench drives each input pulse for exactly one cycle starting at a falling edge and samples at the next falling edge, which is the cycle each result is due. The busy period is timed by counting the falling edges with `busy` high and comparing the count to `WR_CYCLES`. Array contents are read back through the read protocol and compared with a model that the bench updates only when its own reading of the requirements says a commit occurs.

// File: rtl/eeprom_xact_ctrl.sv
module eeprom_xact_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_pins,
  input  logic       wp,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       ack_valid,
  output logic       ack,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  input  logic       mack_valid,
  input  logic       mack,
  output logic       busy
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] PN   = CNT_W'(PAGE_N);

  typedef enum logic [2:0] {S_IDLE, S_DSEL, S_AHI, S_ALO, S_WDAT, S_RD, S_SKIP} st_t;
  st_t state;

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE_N];
  logic [PAGE_N-1:0] pmask;
  logic [ADDR_W-1:0] acnt;
  logic [7:0]        ahi;
  logic [CNT_W-1:0]  bcnt;

  wire        no_evt   = !ev_start && !ev_stop;
  wire        sel_hit  = rx_byte[7:4] == 4'b1010 && rx_byte[3:1] == sel_pins && !busy;
  wire        dsel_in  = no_evt && state == S_DSEL && rx_valid;
  wire        rd_fire  = (dsel_in && sel_hit && rx_byte[0]) ||
                         (no_evt && state == S_RD && mack_valid && mack);
  wire        wr_byte  = no_evt && state == S_WDAT && rx_valid;
  wire [15:0] full_adr = {ahi, rx_byte};
  wire        commit   = busy && bcnt < PN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= 8'h00;
      busy      <= 1'b0;
      bcnt      <= '0;
      acnt      <= '0;
      ahi       <= 8'h00;
      pmask     <= '0;
    end else begin
      ack_valid <= rx_valid;
      ack       <= 1'b0;
      tx_valid  <= rd_fire;
      if (rd_fire) begin
        tx_byte <= mem[acnt];
        acnt    <= acnt + 1'b1;
      end
      if (busy) begin
        bcnt <= bcnt + 1'b1;
        if (bcnt == LAST) busy <= 1'b0;
      end
      if (ev_stop) begin
        if (state == S_WDAT && !wp && |pmask && !busy) begin
          busy <= 1'b1;
          bcnt <= '0;
        end
        state <= S_IDLE;
      end else if (ev_start) begin
        state <= S_DSEL;
      end else begin
        case (state)
          S_DSEL: if (rx_valid) begin
            ack   <= sel_hit;
            state <= !sel_hit ? S_SKIP : (rx_byte[0] ? S_RD : S_AHI);
          end
          S_AHI: if (rx_valid) begin
            ack   <= 1'b1;
            ahi   <= rx_byte;
            state <= S_ALO;
          end
          S_ALO: if (rx_valid) begin
            ack   <= 1'b1;
            acnt  <= full_adr[ADDR_W-1:0];
            pmask <= '0;
            state <= S_WDAT;
          end
          S_WDAT: if (rx_valid) begin
            ack <= 1'b1;
            acnt[PAGE_W-1:0] <= acnt[PAGE_W-1:0] + 1'b1;
            if (!wp) pmask[acnt[PAGE_W-1:0]] <= 1'b1;
          end
          S_RD: if (mack_valid && !mack) state <= S_SKIP;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte && !wp) pbuf[acnt[PAGE_W-1:0]] <= rx_byte;
    if (commit && pmask[bcnt[PAGE_W-1:0]])
      mem[{acnt[ADDR_W-1:PAGE_W], bcnt[PAGE_W-1:0]}] <= pbuf[bcnt[PAGE_W-1:0]];
  end

  p_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> ack_valid);
  p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dsel_in) |=> !ack);
  p_no_tx_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_valid);
  p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop));
  p_wp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && wp) |=> !$rose(busy));
  p_page_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> acnt[ADDR_W-1:PAGE_W] == $past(acnt[ADDR_W-1:PAGE_W]));
  p_seq_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (no_evt && state == S_RD && mack_valid && mack) |=> tx_valid);
endmodule

// File: tb/sim_eeprom_xact_ctrl.sv
module sim_eeprom_xact_ctrl;
  localparam int AW = 12;
  localparam int WRC = 64;
  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;

  logic clk = 0, rst_n = 0, wp = 0, ev_start = 0, ev_stop = 0;
  logic rx_valid = 0, mack_valid = 0, mack = 0;
  logic [7:0] rx_byte = 0;
  logic ack_valid, ack, tx_valid, busy;
  logic [7:0] tx_byte;
  logic [7:0] model [1 << AW];
  int checks = 0, fails = 0, cyc = 0;
  logic txv, a;
  logic [7:0] txd;

  always #10 clk = ~clk;

  eeprom_xact_ctrl #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_pins(3'b101), .wp(wp),
    .ev_start(ev_start), .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .ack_valid(ack_valid), .ack(ack), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .mack_valid(mack_valid), .mack(mack), .busy(busy));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic start_ev(); ev_start = 1; @(negedge clk); ev_start = 0; endtask
  task automatic stop_ev();  ev_stop = 1;  @(negedge clk); ev_stop = 0;  endtask

  task automatic put(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; @(negedge clk); rx_valid = 0;
    a = ack_valid && ack; txv = tx_valid; txd = tx_byte;
  endtask

  task automatic mk(input logic m);
    mack_valid = 1; mack = m; @(negedge clk); mack_valid = 0;
    txv = tx_valid; txd = tx_byte;
  endtask

  task automatic set_addr(input logic [15:0] ad, input string req);
    start_ev();
    put(SEL_W);   chk(a, req, a, 1);
    put(ad[15:8]); chk(a, req, a, 1);
    put(ad[7:0]);  chk(a, req, a, 1);
  endtask

  task automatic wait_commit(input string req);
    int n = 0;
    chk(busy, req, busy, 1);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == WRC, req, n, WRC);
  endtask

  task automatic wr_page(input logic [11:0] ad, input int n, input logic [7:0] base);
    set_addr({4'h0, ad}, "R2");
    for (int i = 0; i < n; i++) begin
      put(base + 8'(i)); chk(a, "R3", a, 1);
      if (!wp) model[{ad[11:5], 5'(ad[4:0] + 5'(i))}] = base + 8'(i);
    end
    stop_ev();
  endtask

  task automatic rd_seq(input logic [11:0] ad, input int n, input string req);
    set_addr({4'h0, ad}, "R7");
    start_ev();
    put(SEL_R); chk(a && txv, req, {a, txv}, 3);
    chk(txd == model[ad], req, txd, model[ad]);
    for (int i = 1; i < n; i++) begin
      mk(1);
      chk(txv && txd == model[12'(ad + 12'(i))], req, txd, model[12'(ad + 12'(i))]);
    end
    mk(0); chk(!txv, "R8", txv, 0);
    stop_ev();
  endtask

  task automatic t_reset();
    chk(!busy && !ack_valid && !tx_valid, "R10", {busy, ack_valid, tx_valid}, 0);
  endtask

  task automatic t_select();
    start_ev(); put(8'hA4); chk(ack_valid && !ack, "R1", {ack_valid, ack}, 2);
    start_ev(); put(8'hBA); chk(ack_valid && !ack, "R1", {ack_valid, ack}, 2);
    put(8'h00); chk(!a, "R1", a, 0);
    stop_ev(); chk(!busy, "R1", busy, 0);
  endtask

  task automatic t_full_page();
    wr_page(12'h080, 32, 8'h10);
    wait_commit("R4");
    rd_seq(12'h080, 32, "R3");
  endtask

  task automatic t_wrap();
    wr_page(12'h05E, 34, 8'h80);
    wait_commit("R4");
    start_ev(); put(SEL_R);
    chk(txv && txd == model[12'h040], "R6", txd, model[12'h040]);
    mk(0); stop_ev();
    rd_seq(12'h05E, 2, "R3");
    rd_seq(12'h040, 3, "R3");
  endtask

  task automatic t_partial();
    wr_page(12'h085, 3, 8'hC0);
    wait_commit("R4");
    rd_seq(12'h084, 5, "R4");
  endtask

  task automatic t_busy();
    wr_page(12'h100, 1, 8'h5A);
    chk(busy, "R5", busy, 1);
    start_ev(); put(SEL_W); chk(ack_valid && !ack, "R5", ack, 0);
    put(8'h01); chk(!a, "R5", a, 0);
    put(8'hEE); chk(!a, "R5", a, 0);
    stop_ev();
    start_ev(); put(SEL_R); chk(!a && !txv, "R5", {a, txv}, 0);
    stop_ev();
    while (busy) @(negedge clk);
    rd_seq(12'h100, 1, "R5");
  endtask

  task automatic t_random_hi();
    set_addr(16'hF085, "R2");
    start_ev(); put(SEL_R);
    chk(txv && txd == model[12'h085], "R2", txd, model[12'h085]);
    mk(0); stop_ev();
    chk(!busy, "R7", busy, 0);
  endtask

  task automatic t_rollover();
    wr_page(12'hFFE, 2, 8'h31); wait_commit("R4");
    wr_page(12'h000, 2, 8'h41); wait_commit("R4");
    rd_seq(12'hFFE, 3, "R8");
    start_ev(); put(SEL_R);
    chk(txv && txd == model[12'h001], "R6", txd, model[12'h001]);
    mk(0); stop_ev();
  endtask

  task automatic t_wp();
    wp = 1;
    wr_page(12'h085, 1, 8'h99);
    chk(!busy, "R9", busy, 0);
    wp = 0;
    rd_seq(12'h085, 1, "R9");
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_select();
    t_full_page();
    t_wrap();
    t_partial();
    t_busy();
    t_random_hi();
    t_rollover();
    t_wp();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule